// File: doc/BRIEF.md
# Periodic Tick Re-arm Engine

This block keeps a periodic tick going on top of an interval timer that raises an interrupt when the low 32 bits of a free-running counter equal a compare value. It holds two things: the expected time of the next tick, at full counter width, and the tick period in cycles. The period is supplied by the surrounding logic. It is normally the cycles-per-10-ms figure times 100, divided by the tick rate. A start strobe arms the first tick one period after the present counter value.

After each timer interrupt, a service strobe makes the engine catch up. It advances the expected tick time by whole periods and counts one elapsed tick for each step. It reports the count with a one-cycle valid pulse, and keeps the result as the new expected tick time. It then works on a separate copy of that deadline. It pushes the copy past the counter if the counter has already overtaken it. It adds one more period if the copy lies within a guard margin of the counter. Finally it writes the low 32 bits of the copy to the compare register. All deadline tests use the modular difference deadline minus counter, so a counter that has wrapped past the deadline reads as a huge value and counts as behind.

The engine makes one addition per clock cycle. The period must stay stable while the engine is busy.

Top module: `tick_rearm_engine`

## Requirements
- R1: A start strobe accepted while idle sets the expected tick time to counter plus period. On the next cycle the engine raises the compare write for one cycle, carrying the low 32 bits of that sum. Start takes priority over service when both arrive in the same idle cycle.
- R2: A service strobe accepted while idle makes the engine add one period to the expected tick time, once per clock cycle. Each addition counts one elapsed tick. The additions stop at the first sum whose modular difference (sum minus counter, taken at counter width) is no greater than one period. The count is therefore always at least 1.
- R3: When accounting ends, the elapsed-tick count is driven on the tick output with a valid pulse exactly one cycle long. The pulse always comes before the compare write of the same service.
- R4: The elapsed-tick count is 16 bits wide and saturates at 65535. The additions still continue until the deadline has caught up.
- R5: The expected tick time kept for the next service is the accounted sum. Periods added later, during catch-up or for the guard margin, are not part of it.
- R6: After accounting, a working copy of the deadline gains one period per cycle, with no tick counted, while its modular difference to the counter exceeds one period.
- R7: If that difference is then 500 cycles or fewer, exactly one more period is added before programming.
- R8: The compare write carries only the low 32 bits of the final working deadline. The counter and deadline are 64 bits wide.
- R9: Busy is high from the cycle after a service is accepted until the compare write cycle, and low in that cycle. Start and service strobes that arrive while busy are ignored. They produce no extra count and no extra compare write.
- R10: After reset, busy, the compare write and the count valid outputs are low, and the compare data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | 64 | Present free-running counter value |
| period_i | input | 64 | Tick period in counter cycles |
| start_i | input | 1 | Arm the first tick from the present counter value |
| service_i | input | 1 | Run tick accounting and re-arm after a timer interrupt |
| cmp_we_o | output | 1 | One-cycle write strobe for the timer compare register |
| cmp_data_o | output | 32 | Value written to the compare register |
| ticks_o | output | 16 | Elapsed-tick count, valid with ticks_vld_o |
| ticks_vld_o | output | 1 | One-cycle pulse marking the count |
| busy_o | output | 1 | Engine is stepping a service request |

## Verification
The bench goes after three corner cases.

The first is a deadline and counter that straddle the 64-bit wrap. A design that compares deadline and counter by magnitude instead of by modular difference would stall, or would program a deadline four billion cycles late.

The second moves the counter between accounting and programming. This forces uncounted catch-up periods. A design that counts them, or that stores the pushed deadline as the expected tick time, shows up on the next service as a wrong count.

The third runs a service whose remaining difference is exactly 500. It also runs a backlog long enough to saturate the count, and it re-strobes start and service while busy. An off-by-one guard, a wrapping counter, or an engine that accepts a second request shows up as a wrong compare value or as an unexpected extra pulse.

// File: rtl/tre_pkg.sv
package tre_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACCT = 2'd1,
        ST_SKIP = 2'd2
    } tre_state_e;

endpackage

// File: rtl/tre_gap_cmp.sv
// Wrap-safe deadline test: the modular difference deadline - now is compared
// against one period (still behind) and against the delivery guard (too near).
module tre_gap_cmp #(
    parameter int CNT_W = 64,
    parameter int GUARD = 500
) (
    input  logic [CNT_W-1:0] deadline_i,
    input  logic [CNT_W-1:0] now_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             behind_o,
    output logic             near_o
);
    localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD);

    logic [CNT_W-1:0] gap;

    always_comb begin
        gap      = deadline_i - now_i;
        behind_o = gap > period_i;
        near_o   = gap <= GUARD_V;
    end

endmodule

// File: rtl/tre_sat_inc.sv
// Saturating increment for the elapsed-tick count.
module tre_sat_inc #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        if (val_i == TOP) val_o = TOP;
        else              val_o = val_i + W'(1);
    end

endmodule

// File: rtl/tick_rearm_engine.sv
module tick_rearm_engine #(
    parameter int CNT_W  = 64,
    parameter int CMP_W  = 32,
    parameter int TICK_W = 16,
    parameter int GUARD  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  now_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              start_i,
    input  logic              service_i,
    output logic              cmp_we_o,
    output logic [CMP_W-1:0]  cmp_data_o,
    output logic [TICK_W-1:0] ticks_o,
    output logic              ticks_vld_o,
    output logic              busy_o
);
    import tre_pkg::*;

    typedef struct packed {
        tre_state_e        st;
        logic [CNT_W-1:0]  dl;     // expected time of the next tick
        logic [CNT_W-1:0]  wk;     // working deadline for programming
        logic [TICK_W-1:0] cnt;    // ticks counted so far
        logic [TICK_W-1:0] ticks;  // reported count
        logic              vld;
        logic              we;
        logic [CMP_W-1:0]  cdata;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [CNT_W-1:0]  arm_sum;
    logic [CNT_W-1:0]  dl_sum;
    logic [CNT_W-1:0]  wk_sum;
    logic [CNT_W-1:0]  probe;
    logic [TICK_W-1:0] cnt_inc;
    logic              behind;
    logic              near;

    always_comb begin
        arm_sum = now_i + period_i;
        dl_sum  = cur_q.dl + period_i;
        wk_sum  = cur_q.wk + period_i;
        probe   = (cur_q.st == ST_ACCT) ? dl_sum : cur_q.wk;
    end

    tre_gap_cmp #(
        .CNT_W (CNT_W),
        .GUARD (GUARD)
    ) u_gap (
        .deadline_i (probe),
        .now_i      (now_i),
        .period_i   (period_i),
        .behind_o   (behind),
        .near_o     (near)
    );

    tre_sat_inc #(
        .W (TICK_W)
    ) u_inc (
        .val_i (cur_q.cnt),
        .val_o (cnt_inc)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        nxt_d.we  = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.dl    = arm_sum;
                    nxt_d.we    = 1'b1;
                    nxt_d.cdata = arm_sum[CMP_W-1:0];
                end else if (service_i) begin
                    nxt_d.st  = ST_ACCT;
                    nxt_d.cnt = '0;
                end
            end
            ST_ACCT: begin
                nxt_d.dl  = dl_sum;
                nxt_d.cnt = cnt_inc;
                if (!behind) begin
                    nxt_d.st    = ST_SKIP;
                    nxt_d.wk    = dl_sum;
                    nxt_d.vld   = 1'b1;
                    nxt_d.ticks = cnt_inc;
                end
            end
            ST_SKIP: begin
                if (behind) begin
                    nxt_d.wk = wk_sum;
                end else begin
                    nxt_d.st = ST_IDLE;
                    nxt_d.we = 1'b1;
                    if (near) begin
                        nxt_d.wk    = wk_sum;
                        nxt_d.cdata = wk_sum[CMP_W-1:0];
                    end else begin
                        nxt_d.cdata = cur_q.wk[CMP_W-1:0];
                    end
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        cmp_we_o    = cur_q.we;
        cmp_data_o  = cur_q.cdata;
        ticks_o     = cur_q.ticks;
        ticks_vld_o = cur_q.vld;
        busy_o      = cur_q.st != ST_IDLE;
    end

endmodule

// File: rtl/tre_checker.sv
module tre_checker #(
    parameter int CNT_W  = 64,
    parameter int CMP_W  = 32,
    parameter int TICK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  now_i,
    input logic [CNT_W-1:0]  period_i,
    input logic              start_i,
    input logic              service_i,
    input logic              cmp_we_o,
    input logic [CMP_W-1:0]  cmp_data_o,
    input logic [TICK_W-1:0] ticks_o,
    input logic              ticks_vld_o,
    input logic              busy_o
);
    logic [CMP_W-1:0] arm_low;
    assign arm_low = now_i[CMP_W-1:0] + period_i[CMP_W-1:0];

    p_start_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (cmp_we_o && cmp_data_o == $past(arm_low)));

    p_count_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_vld_o |-> (ticks_o != '0));

    p_vld_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_vld_o |=> !ticks_vld_o);

    p_vld_before_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_vld_o |-> (busy_o && !cmp_we_o));

    p_write_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_o |-> !busy_o);

    p_busy_ends_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> cmp_we_o);

    p_service_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (service_i && !start_i && !busy_o) |=> busy_o);

endmodule

bind tick_rearm_engine tre_checker #(
    .CNT_W  (CNT_W),
    .CMP_W  (CMP_W),
    .TICK_W (TICK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .now_i       (now_i),
    .period_i    (period_i),
    .start_i     (start_i),
    .service_i   (service_i),
    .cmp_we_o    (cmp_we_o),
    .cmp_data_o  (cmp_data_o),
    .ticks_o     (ticks_o),
    .ticks_vld_o (ticks_vld_o),
    .busy_o      (busy_o)
);

// File: tb/tick_rearm_engine_test.sv
module tick_rearm_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now_i = '0;
    logic [63:0] period_i = 64'd1000;
    logic        start_i = 1'b0;
    logic        service_i = 1'b0;
    logic        cmp_we_o;
    logic [31:0] cmp_data_o;
    logic [15:0] ticks_o;
    logic        ticks_vld_o;
    logic        busy_o;

    int total = 0;
    int bad = 0;

    logic [31:0] exp_cmp[$];
    string       cmp_tag[$];
    logic [15:0] exp_tk[$];
    string       tk_tag[$];

    longint unsigned model_dl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_rearm_engine uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .now_i       (now_i),
        .period_i    (period_i),
        .start_i     (start_i),
        .service_i   (service_i),
        .cmp_we_o    (cmp_we_o),
        .cmp_data_o  (cmp_data_o),
        .ticks_o     (ticks_o),
        .ticks_vld_o (ticks_vld_o),
        .busy_o      (busy_o)
    );

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected results as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmp_we_o) begin
                if (exp_cmp.size() == 0) begin
                    check(1'b0, "R9 unexpected compare write", cmp_data_o, 0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_cmp.pop_front();
                    t = cmp_tag.pop_front();
                    check(cmp_data_o == e, t, cmp_data_o, e);
                end
            end
            if (ticks_vld_o) begin
                if (exp_tk.size() == 0) begin
                    check(1'b0, "R9 unexpected count pulse", ticks_o, 0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_tk.pop_front();
                    t = tk_tag.pop_front();
                    check(ticks_o == e, t, ticks_o, e);
                end
            end
        end
    end

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_start(input longint unsigned now, input string tag);
        @(negedge clk);
        now_i   = now;
        start_i = 1'b1;
        model_dl = now + period_i;
        exp_cmp.push_back(model_dl[31:0]);
        cmp_tag.push_back(tag);
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
    endtask

    // a: counter during accounting; b: counter seen by catch-up and guard
    task automatic do_service(input longint unsigned a, input longint unsigned b,
                              input bit inject, input string tag);
        longint unsigned p;
        longint unsigned wk;
        int k;
        p = period_i;
        k = 0;
        do begin
            model_dl = model_dl + p;
            k++;
        end while ((model_dl - a) > p);
        exp_tk.push_back((k > 65535) ? 16'hFFFF : 16'(k));
        tk_tag.push_back({tag, " count"});
        wk = model_dl;
        while ((wk - b) > p) wk = wk + p;
        if ((wk - b) <= 64'd500) wk = wk + p;
        exp_cmp.push_back(wk[31:0]);
        cmp_tag.push_back({tag, " compare"});

        @(negedge clk);
        now_i     = a;
        service_i = 1'b1;
        @(negedge clk);
        service_i = inject;
        start_i   = inject;
        if (inject) check(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            service_i = 1'b0;
            start_i   = 1'b0;
        end
        now_i = b;
        wait_idle();
        check(busy_o == 1'b0, {tag, " R9 idle after write"}, busy_o, 0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R10 busy in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmp_we_o == 1'b0, "R10 write after reset", cmp_we_o, 0);
        check(ticks_vld_o == 1'b0, "R10 valid after reset", ticks_vld_o, 0);
        check(cmp_data_o == 32'd0, "R10 data after reset", cmp_data_o, 0);

        // R1: arm from 5000 -> 6000
        do_start(64'd5000, "R1 start");
        // R2: one tick late by 10 cycles
        do_service(64'd6010, 64'd6010, 1'b0, "R2 single tick");
        // R2/R7: three ticks, gap exactly 500 takes guard period; R9 re-strobes ignored
        do_service(64'd9500, 64'd9500, 1'b1, "R7 guard and R9 ignore");
        // R5: expected time is 10000, not the guarded 11000
        do_service(64'd10100, 64'd10100, 1'b0, "R5 stored deadline");
        // R6: counter jumps before programming, uncounted catch-up
        do_service(64'd11500, 64'd14200, 1'b0, "R6 catch-up");
        // R5: next count reveals stored deadline 12000
        do_service(64'd14300, 64'd14300, 1'b0, "R5 after catch-up");
        // R8: low 32 bits only
        do_start(64'h1_FFFF_FF00, "R8 low bits start");
        do_service(64'h2_0000_0300, 64'h2_0000_0300, 1'b0, "R8 low bits service");
        // R2: wrap of the 64-bit counter
        do_start(64'hFFFF_FFFF_FFFF_FAEC, "R1 start near wrap");
        do_service(64'd200, 64'd200, 1'b0, "R2 wrap");
        // R4: long backlog saturates the count
        do_start(64'd0, "R1 restart");
        do_service(64'd66000000, 64'd66000000, 1'b0, "R4 saturation");

        check(exp_cmp.size() == 0, "R9 pending compare writes", exp_cmp.size(), 0);
        check(exp_tk.size() == 0, "R3 pending counts", exp_tk.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule